// File: doc/BRIEF.md
# Over-current Blanking and Latch-off Controller

This block is the digital protection sequencer of a smart high-side switch. It turns an output-enable request into a gate-enable signal and shuts that gate down when the load misbehaves. Two external comparators report whether the load current is above a low threshold or above a high threshold. A stay above the low threshold is allowed for a programmable blanking time before the gate is latched off, which lets loads with a large inrush current start. A stay above the high threshold trips the gate almost at once, after a short glitch filter. Together the two tiers act like a slow-blow fuse.

All timing counts pulses of a `tick` input, a timebase supplied by the chip (for example one pulse per microsecond). Four blanking counts are parameters, chosen by a 2-bit select field from the register bank. A timeout-disable bit removes the low-threshold trip entirely. An open-load comparator is debounced and reported while the gate is on, unless an open-load disable bit masks it. A latched trip keeps the gate off and keeps its sticky fault flag until the enable request is driven low and then high again.

The sequencer has four states. IDLE: the gate is off and no fault is held. DRIVE: the gate is on. TRIPPED: a fault is latched while the request is still high. HOLD: a fault is latched and the request has gone low. Transitions: ENABLE (IDLE to DRIVE when the request is high), DISABLE (DRIVE to IDLE when the request is low and no trip occurs), TRIP (DRIVE to TRIPPED on a high-threshold trip or an unmasked low-threshold timeout; a trip wins over DISABLE in the same cycle), WAIT_LOW (TRIPPED to HOLD when the request goes low), REARM (HOLD to DRIVE when the request goes high, which clears the fault flags).

Top module: `ocp_guard`

## Requirements
- R1: During and after reset the gate output and all three fault flags are 0 and the sequencer is in IDLE.
- R2: With no fault, a request sampled high drives `gate_on` to 1 at the next clock edge, and a request sampled low drives it to 0 at the next clock edge.
- R3: `blank_sel` values 0, 1, 2 and 3 select the blanking counts BLANK_T0, BLANK_T1, BLANK_T2 and BLANK_T3. When `oc_lo` stays high for that many ticks while the gate is on, `gate_on` falls and `flt_lo` rises at the clock edge after the tick that completes the count.
- R4: If `oc_lo` falls before the blanking count completes, the count restarts from zero when `oc_lo` rises again.
- R5: While `tmo_dis` is 1, `oc_lo` never turns the gate off and never sets `flt_lo`, however long it lasts.
- R6: When `oc_hi` stays high for HI_FILT ticks while the gate is on, `gate_on` falls and `flt_hi` rises at the next edge, whatever `blank_sel` and `tmo_dis` are. A pulse shorter than HI_FILT ticks has no effect.
- R7: After a trip, `gate_on` stays 0 and the fault flag stays 1 while the request stays high and also after it falls. The next rising request turns the gate on and clears both flags at the same edge.
- R8: With the gate on, `ol_det` held for OL_DEB ticks sets `flt_ol` while `ol_det` stays high. `flt_ol` is 0 whenever `ol_dis` is 1, `ol_det` is 0 or the gate is off, and it never turns the gate off.
- R9: The timers advance only on clock edges where `tick` is 1. With `tick` held at 0, no persisting condition ever trips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse that advances all timers |
| en_req | input | 1 | Output-enable request |
| oc_hi | input | 1 | High-threshold over-current comparator flag |
| oc_lo | input | 1 | Low-threshold over-current comparator flag |
| ol_det | input | 1 | Open-load comparator flag |
| blank_sel | input | 2 | Blanking count select (0..3 to BLANK_T0..BLANK_T3) |
| tmo_dis | input | 1 | 1 disables the low-threshold timeout trip |
| ol_dis | input | 1 | 1 masks open-load reporting |
| gate_on | output | 1 | Gate enable for the power switch |
| flt_lo | output | 1 | Sticky low-threshold timeout fault |
| flt_hi | output | 1 | Sticky high-threshold fault |
| flt_ol | output | 1 | Debounced open-load flag |

## Verification
The low-threshold path is tried with every select value, and the exact trip edge is measured each time, so a wrong table entry or an off-by-one count shows up. A held condition is compared with one that drops for a cycle and resumes, which tells a restarting timer from one that only pauses. A condition held while the timebase is stopped shows whether the timers count ticks or clock cycles. High-threshold pulses one tick shorter than the filter and exactly as long as the filter tell the glitch filter from a direct trip. The latch is released in two steps, request low and then high, to show that the fault is held through the low phase and cleared only on the rising request.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_TRIPPED = 2'd2,
        ST_HOLD    = 2'd3
    } ocp_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ocp_persist_cnt.sv
module ocp_persist_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         cond,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = cond && !clr && (cnt_q >= limit);

endmodule

// File: rtl/ocp_fsm.sv
module ocp_fsm
    import ocp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic hi_exp,
    input  logic lo_exp,
    input  logic tmo_dis,
    output logic gate_on,
    output logic flt_lo,
    output logic flt_hi
);

    ocp_state_e state_q, state_d;
    logic       trip_hi, trip_lo, trip_any;
    logic       flt_lo_q, flt_hi_q;

    assign trip_hi  = hi_exp;
    assign trip_lo  = lo_exp && !tmo_dis;
    assign trip_any = trip_hi || trip_lo;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_req) state_d = ST_DRIVE;          // ENABLE
            end
            ST_DRIVE: begin
                if (trip_any)     state_d = ST_TRIPPED;  // TRIP
                else if (!en_req) state_d = ST_IDLE;     // DISABLE
            end
            ST_TRIPPED: begin
                if (!en_req) state_d = ST_HOLD;          // WAIT_LOW
            end
            ST_HOLD: begin
                if (en_req) state_d = ST_DRIVE;          // REARM
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sticky fault flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_lo_q <= 1'b0;
            flt_hi_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DRIVE: begin
                    if (trip_hi) flt_hi_q <= 1'b1;
                    if (trip_lo) flt_lo_q <= 1'b1;
                end
                ST_HOLD: begin
                    if (en_req) begin
                        flt_hi_q <= 1'b0;
                        flt_lo_q <= 1'b0;
                    end
                end
                default: begin
                    flt_hi_q <= flt_hi_q;
                    flt_lo_q <= flt_lo_q;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        gate_on = (state_q == ST_DRIVE);
        flt_lo  = flt_lo_q;
        flt_hi  = flt_hi_q;
    end

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
    import ocp_pkg::*;
#(
    parameter int unsigned BLANK_T0 = 150,
    parameter int unsigned BLANK_T1 = 1200,
    parameter int unsigned BLANK_T2 = 10000,
    parameter int unsigned BLANK_T3 = 155000,
    parameter int unsigned HI_FILT  = 4,
    parameter int unsigned OL_DEB   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en_req,
    input  logic       oc_hi,
    input  logic       oc_lo,
    input  logic       ol_det,
    input  logic [1:0] blank_sel,
    input  logic       tmo_dis,
    input  logic       ol_dis,
    output logic       gate_on,
    output logic       flt_lo,
    output logic       flt_hi,
    output logic       flt_ol
);

    localparam int unsigned LIM_MAX = max4(max4(BLANK_T0, BLANK_T1, BLANK_T2, BLANK_T3),
                                           HI_FILT, OL_DEB, 1);
    localparam int unsigned CW      = $clog2(LIM_MAX + 1);
    localparam int unsigned NSEL    = 4;

    localparam logic [CW-1:0] BLANK_TBL [NSEL] = '{
        CW'(BLANK_T0), CW'(BLANK_T1), CW'(BLANK_T2), CW'(BLANK_T3)
    };

    logic          drive_off;
    logic          lo_exp, hi_exp, ol_exp;
    logic [CW-1:0] blank_lim;

    assign drive_off = !gate_on;
    assign blank_lim = BLANK_TBL[blank_sel];

    ocp_persist_cnt #(.W(CW)) u_lo_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (drive_off),
        .tick   (tick),
        .cond   (oc_lo),
        .limit  (blank_lim),
        .expired(lo_exp)
    );

    ocp_persist_cnt #(.W(CW)) u_hi_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (drive_off),
        .tick   (tick),
        .cond   (oc_hi),
        .limit  (CW'(HI_FILT)),
        .expired(hi_exp)
    );

    ocp_persist_cnt #(.W(CW)) u_ol_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (drive_off),
        .tick   (tick),
        .cond   (ol_det),
        .limit  (CW'(OL_DEB)),
        .expired(ol_exp)
    );

    ocp_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_req (en_req),
        .hi_exp (hi_exp),
        .lo_exp (lo_exp),
        .tmo_dis(tmo_dis),
        .gate_on(gate_on),
        .flt_lo (flt_lo),
        .flt_hi (flt_hi)
    );

    assign flt_ol = ol_exp && !ol_dis;

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic en_req,
    input logic tmo_dis,
    input logic ol_dis,
    input logic gate_on,
    input logic flt_lo,
    input logic flt_hi,
    input logic flt_ol
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!gate_on && !flt_lo && !flt_hi && !flt_ol));

    // R2
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(en_req));

    // R5
    lo_flag_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_lo) |-> !$past(tmo_dis));

    // R3
    lo_trip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_lo) |-> $fell(gate_on));

    // R6
    hi_trip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_hi) |-> $fell(gate_on));

    // R7
    fault_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_lo || flt_hi) |-> !gate_on);

    // R7
    fault_clear_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flt_hi) || $fell(flt_lo)) |-> ($past(en_req) && gate_on));

    // R8
    ol_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_ol |-> (gate_on && !ol_dis));

endmodule

bind ocp_guard ocp_guard_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_req (en_req),
    .tmo_dis(tmo_dis),
    .ol_dis (ol_dis),
    .gate_on(gate_on),
    .flt_lo (flt_lo),
    .flt_hi (flt_hi),
    .flt_ol (flt_ol)
);

// File: tb/ocp_guard_tb.sv
`timescale 1ns/1ps
module ocp_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T0 = 5;
    localparam int T1 = 8;
    localparam int T2 = 12;
    localparam int T3 = 20;
    localparam int HF = 3;
    localparam int OLD = 4;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       en_req = 1'b0;
    logic       oc_hi = 1'b0;
    logic       oc_lo = 1'b0;
    logic       ol_det = 1'b0;
    logic [1:0] blank_sel = 2'd0;
    logic       tmo_dis = 1'b0;
    logic       ol_dis = 1'b0;
    logic       gate_on, flt_lo, flt_hi, flt_ol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_guard #(
        .BLANK_T0(T0), .BLANK_T1(T1), .BLANK_T2(T2), .BLANK_T3(T3),
        .HI_FILT(HF), .OL_DEB(OLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en_req(en_req),
        .oc_hi(oc_hi), .oc_lo(oc_lo), .ol_det(ol_det), .blank_sel(blank_sel),
        .tmo_dis(tmo_dis), .ol_dis(ol_dis),
        .gate_on(gate_on), .flt_lo(flt_lo), .flt_hi(flt_hi), .flt_ol(flt_ol)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drop and raise the request so the gate is on with no fault held.
    task automatic rearm();
        en_req = 1'b0;
        step(2);
        en_req = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1", "gate", gate_on, 0);
        chk("R1", "flags", {flt_lo, flt_hi, flt_ol}, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1", "gate after reset", gate_on, 0);
    endtask

    task automatic t_enable();
        en_req = 1'b1;
        @(posedge clk); #1;
        chk("R2", "gate after enable edge", gate_on, 1);
        @(negedge clk);
        en_req = 1'b0;
        step(1);
        chk("R2", "gate after disable", gate_on, 0);
        en_req = 1'b1;
        step(1);
        chk("R2", "gate re-enabled", gate_on, 1);
    endtask

    task automatic t_lo_blank(input logic [1:0] sel, input int lim);
        rearm();
        blank_sel = sel;
        oc_lo = 1'b1;
        step(lim);
        chk("R3", $sformatf("gate before expiry sel=%0d", sel), gate_on, 1);
        chk("R3", $sformatf("flt_lo before expiry sel=%0d", sel), flt_lo, 0);
        step(1);
        chk("R3", $sformatf("gate after expiry sel=%0d", sel), gate_on, 0);
        chk("R3", $sformatf("flt_lo after expiry sel=%0d", sel), flt_lo, 1);
        oc_lo = 1'b0;
    endtask

    task automatic t_lo_restart();
        rearm();
        blank_sel = 2'd0;
        oc_lo = 1'b1;
        step(T0 - 1);
        oc_lo = 1'b0;
        step(1);
        oc_lo = 1'b1;
        step(T0);
        chk("R4", "gate on after restarted count", gate_on, 1);
        step(1);
        chk("R4", "gate off after full count", gate_on, 0);
        oc_lo = 1'b0;
    endtask

    task automatic t_tmo_dis();
        rearm();
        tmo_dis = 1'b1;
        blank_sel = 2'd0;
        oc_lo = 1'b1;
        step(5 * T3);
        chk("R5", "gate with timeout disabled", gate_on, 1);
        chk("R5", "flt_lo with timeout disabled", flt_lo, 0);
        oc_lo = 1'b0;
        step(1);
        tmo_dis = 1'b0;
    endtask

    task automatic t_hi_trip();
        rearm();
        tmo_dis = 1'b1;
        blank_sel = 2'd3;
        oc_hi = 1'b1;
        step(HF);
        chk("R6", "gate before hi filter done", gate_on, 1);
        step(1);
        chk("R6", "gate after hi trip", gate_on, 0);
        chk("R6", "flt_hi after hi trip", flt_hi, 1);
        chk("R6", "flt_lo untouched", flt_lo, 0);
        oc_hi = 1'b0;
        tmo_dis = 1'b0;
    endtask

    task automatic t_hi_glitch();
        rearm();
        oc_hi = 1'b1;
        step(HF - 1);
        oc_hi = 1'b0;
        step(1);
        oc_hi = 1'b1;
        step(HF - 1);
        oc_hi = 1'b0;
        step(10);
        chk("R6", "gate after short hi pulses", gate_on, 1);
        chk("R6", "flt_hi after short hi pulses", flt_hi, 0);
    endtask

    task automatic t_latch_release();
        rearm();
        oc_hi = 1'b1;
        step(HF + 1);
        oc_hi = 1'b0;
        step(4);
        chk("R7", "gate held off, request high", gate_on, 0);
        chk("R7", "flt_hi held, request high", flt_hi, 1);
        en_req = 1'b0;
        step(3);
        chk("R7", "gate off, request low", gate_on, 0);
        chk("R7", "flt_hi held, request low", flt_hi, 1);
        en_req = 1'b1;
        step(1);
        chk("R7", "gate on after rearm", gate_on, 1);
        chk("R7", "flt_hi cleared after rearm", flt_hi, 0);
    endtask

    task automatic t_open_load();
        rearm();
        ol_det = 1'b1;
        step(OLD - 1);
        chk("R8", "flt_ol before debounce", flt_ol, 0);
        step(1);
        chk("R8", "flt_ol after debounce", flt_ol, 1);
        step(5);
        chk("R8", "gate stays on with open load", gate_on, 1);
        ol_dis = 1'b1;
        #1;
        chk("R8", "flt_ol masked", flt_ol, 0);
        step(5);
        chk("R8", "flt_ol masked held", flt_ol, 0);
        ol_dis = 1'b0;
        #1;
        chk("R8", "flt_ol unmasked", flt_ol, 1);
        ol_det = 1'b0;
        #1;
        chk("R8", "flt_ol drops with ol_det", flt_ol, 0);
        en_req = 1'b0;
        ol_det = 1'b1;
        step(OLD + 2);
        chk("R8", "flt_ol with gate off", flt_ol, 0);
        ol_det = 1'b0;
    endtask

    task automatic t_tick_hold();
        rearm();
        blank_sel = 2'd0;
        tick = 1'b0;
        oc_lo = 1'b1;
        step(6 * T0);
        chk("R9", "gate on while tick low", gate_on, 1);
        tick = 1'b1;
        step(T0);
        chk("R9", "gate on before ticks complete", gate_on, 1);
        step(1);
        chk("R9", "gate off after ticks complete", gate_on, 0);
        oc_lo = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable();
        t_lo_blank(2'd0, T0);
        t_lo_blank(2'd1, T1);
        t_lo_blank(2'd2, T2);
        t_lo_blank(2'd3, T3);
        t_lo_restart();
        t_tmo_dis();
        t_hi_trip();
        t_hi_glitch();
        t_latch_release();
        t_open_load();
        t_tick_hold();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

endmodule